// File: doc/BRIEF.md
# Indexed real-time clock register file with periodic tick

The block sits on a byte-wide host bus. It holds the time and calendar bytes of a real-time clock and the clock's status and control registers, and it generates a periodic interrupt. The host uses two ports. A write to the index port selects a register. A read or write of the data port then reaches that register.

Indices 0x0 to 0x9 are a plain array of calendar bytes, loaded from parameters at reset. The calendar does not advance by itself. Indices 0xA and 0xB are the status and control registers. Indices 0xC and 0xD read as zero.

The periodic generator counts `PERIOD_CYCLES` clocks, which must be at least 2. On each terminal count it emits a one-cycle pulse, and it runs only while the enable bit of the control register is set. Any write that the block cannot honour is dropped, and the error output pulses for one cycle.

Requests arrive on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read puts its byte into a one-entry response register on the next cycle, and that byte stays there until it is taken on an edge with `rsp_ready` high. While the response is waiting and `rsp_ready` is low, `req_ready` stays low, which stalls further requests. Writes produce no response.

Top module: `rtcp_periodic_regfile`

## Requirements
- R1: A write of 0x00..0x0D to the index port (req_port=0) stores it. A larger value is not stored and raises the error pulse. A read of the index port returns the stored index.
- R2: Through the data port (req_port=1), indices 0x0..0x9 write and read back ordinary bytes.
- R3: The reset contents of the calendar bytes are as follows. The layout is seconds at 0, minutes at 2 and hours at 4. Day of week is at 6, with INIT_WDAY+1 stored so that 1 means Sunday. Day of month is at 7. Month is at 8, with INIT_MONTH+1 stored so that months run 1..12. Year is at 9. Indices 1, 3 and 5 are zero.
- R4: The year byte depends on YEAR_BCD. When it is set, the byte is INIT_YEAR mod 100 packed as tens in bits 7:4 and ones in bits 3:0. When it is clear, the byte is INIT_YEAR (years since 1900).
- R5: After reset, status register A (index 0xA) holds 0x26 and control register B (index 0xB) holds 0x46. In register B, bit 6 is the tick enable, bit 3 is free, bit 2 selects binary mode and bit 1 selects 24-hour mode.
- R6: Every read of register A inverts its bit 7 and returns the inverted value. The first read after reset returns 0xA6, and the next returns 0x26.
- R7: Register A accepts a write only of 0x26. Any other value is dropped and raises the error pulse.
- R8: Register B accepts a write only if (value AND 0xB7) equals 0x06. Any other value is dropped and raises the error pulse. An accepted value reads back unchanged.
- R9: Registers C and D (indices 0xC and 0xD) read 0x00. Any write to them raises the error pulse, and they still read 0x00 afterwards.
- R10: While the generator is enabled, `tick_irq` is high for exactly one cycle every PERIOD_CYCLES clocks. The first pulse is seen after the PERIOD_CYCLES-th edge after reset, or after the edge that takes an enabling write while the generator is stopped.
- R11: An accepted write to register B with bit 6 clear stops the generator. No pulse follows until an accepted write sets bit 6 again.
- R12: A stopping write taken on the edge of a terminal count wins, and that pulse is not produced.
- R13: A read response appears on the cycle after acceptance. While `rsp_ready` is low, it holds its data and `req_ready` stays low. The error pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 1 | 0 = index port, 1 = data port |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 8 | Read response byte |
| err_pulse | output | 1 | One-cycle flag for a dropped write |
| tick_irq | output | 1 | One-cycle periodic interrupt |

## Verification
A host write to control register B and the generator's terminal count can land on the same clock edge. The bench re-enables the generator and counts cycles from the edge that takes the enabling write. It then times a stopping write so that it is taken on exactly the edge of the second terminal count. The outcome is judged at the interrupt pin: there must be no pulse after that edge, nor for several periods afterwards. A second collision case stalls the response channel while a write is offered, then checks through the index port that the write was taken only after the stall released.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
  localparam int DATA_W    = 8;
  localparam int IDX_W     = 4;
  localparam int CAL_BYTES = 10;

  localparam logic [IDX_W-1:0] IDX_STAT_A = 4'hA;
  localparam logic [IDX_W-1:0] IDX_CTRL_B = 4'hB;
  localparam logic [IDX_W-1:0] IDX_LAST   = 4'hD;

  // calendar slot positions
  localparam int SLOT_SEC  = 0;
  localparam int SLOT_MIN  = 2;
  localparam int SLOT_HOUR = 4;
  localparam int SLOT_WDAY = 6;
  localparam int SLOT_MDAY = 7;
  localparam int SLOT_MON  = 8;
  localparam int SLOT_YEAR = 9;

  localparam logic [DATA_W-1:0] A_UIP   = 8'h80;
  localparam logic [DATA_W-1:0] A_RESET = 8'h26;
  localparam logic [DATA_W-1:0] B_TIE   = 8'h40;
  localparam logic [DATA_W-1:0] B_SQW   = 8'h08;
  localparam logic [DATA_W-1:0] B_BIN   = 8'h04;
  localparam logic [DATA_W-1:0] B_H24   = 8'h02;
  localparam logic [DATA_W-1:0] B_FREE  = B_TIE | B_SQW;
  localparam logic [DATA_W-1:0] B_FIXED = B_BIN | B_H24;
  localparam logic [DATA_W-1:0] B_RESET = B_TIE | B_FIXED;

  typedef enum logic {PORT_INDEX = 1'b0, PORT_DATA = 1'b1} port_e;

  function automatic logic [DATA_W-1:0] pack_bcd2(input int v);
    int y;
    y = v % 100;
    return DATA_W'(((y / 10) << 4) | (y % 10));
  endfunction
endpackage

// File: rtl/rtcp_host_port.sv
module rtcp_host_port
  import rtcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  output logic              req_ready,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] rd_value,
  output logic              accept
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rtcp_regfile.sv
module rtcp_regfile
  import rtcp_pkg::*;
#(
  parameter int INIT_SEC   = 0,
  parameter int INIT_MIN   = 0,
  parameter int INIT_HOUR  = 0,
  parameter int INIT_WDAY  = 0,
  parameter int INIT_MDAY  = 1,
  parameter int INIT_MONTH = 0,
  parameter int INIT_YEAR  = 100,
  parameter bit YEAR_BCD   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              wr,
  input  logic              port,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_value,
  output logic              err_pulse,
  output logic              tmr_start,
  output logic              tmr_stop,
  output logic [IDX_W-1:0]  idx_q,
  output logic [DATA_W-1:0] stat_a
);
  function automatic logic [DATA_W-1:0] cal_init(input int slot);
    case (slot)
      SLOT_SEC:  return DATA_W'(INIT_SEC);
      SLOT_MIN:  return DATA_W'(INIT_MIN);
      SLOT_HOUR: return DATA_W'(INIT_HOUR);
      SLOT_WDAY: return DATA_W'(INIT_WDAY + 1);
      SLOT_MDAY: return DATA_W'(INIT_MDAY);
      SLOT_MON:  return DATA_W'(INIT_MONTH + 1);
      SLOT_YEAR: return YEAR_BCD ? pack_bcd2(INIT_YEAR) : DATA_W'(INIT_YEAR);
      default:   return '0;
    endcase
  endfunction

  logic [DATA_W-1:0] cal_q [CAL_BYTES];
  logic [DATA_W-1:0] ctrl_b;
  logic [DATA_W-1:0] cal_rd;
  logic wr_index, wr_data, rd_data;
  logic idx_ok, a_ok, b_ok, in_cal, bad;

  assign wr_index = accept && wr && (port == PORT_INDEX);
  assign wr_data  = accept && wr && (port == PORT_DATA);
  assign rd_data  = accept && !wr && (port == PORT_DATA);
  assign idx_ok   = wdata <= {{(DATA_W-IDX_W){1'b0}}, IDX_LAST};
  assign a_ok     = wdata == A_RESET;
  assign b_ok     = (wdata & ~B_FREE) == B_FIXED;
  assign in_cal   = idx_q < IDX_STAT_A;

  always_comb begin
    bad = 1'b0;
    if (wr_index && !idx_ok) bad = 1'b1;
    if (wr_data && !in_cal) begin
      if (idx_q == IDX_STAT_A)      bad = !a_ok;
      else if (idx_q == IDX_CTRL_B) bad = !b_ok;
      else                          bad = 1'b1;
    end
  end

  assign tmr_start = wr_data && (idx_q == IDX_CTRL_B) && b_ok && ((wdata & B_TIE) != '0);
  assign tmr_stop  = wr_data && (idx_q == IDX_CTRL_B) && b_ok && ((wdata & B_TIE) == '0);

  for (genvar g = 0; g < CAL_BYTES; g++) begin : g_cal
    always_ff @(posedge clk) begin
      if (!rst_n)                                 cal_q[g] <= cal_init(g);
      else if (wr_data && (idx_q == IDX_W'(g)))   cal_q[g] <= wdata;
    end
  end

  always_comb begin
    cal_rd = '0;
    for (int i = 0; i < CAL_BYTES; i++)
      if (idx_q == IDX_W'(i)) cal_rd = cal_q[i];
  end

  always_comb begin
    if (port == PORT_INDEX)         rd_value = {{(DATA_W-IDX_W){1'b0}}, idx_q};
    else if (in_cal)                rd_value = cal_rd;
    else if (idx_q == IDX_STAT_A)   rd_value = stat_a ^ A_UIP;
    else if (idx_q == IDX_CTRL_B)   rd_value = ctrl_b;
    else                            rd_value = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      stat_a    <= A_RESET;
      ctrl_b    <= B_RESET;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= bad;
      if (wr_index && idx_ok) idx_q <= wdata[IDX_W-1:0];
      if (wr_data && (idx_q == IDX_STAT_A) && a_ok)      stat_a <= wdata;
      else if (rd_data && (idx_q == IDX_STAT_A))         stat_a <= stat_a ^ A_UIP;
      if (wr_data && (idx_q == IDX_CTRL_B) && b_ok)      ctrl_b <= wdata;
    end
  end
endmodule

// File: rtl/rtcp_tick_timer.sv
module rtcp_tick_timer #(
  parameter int PERIOD   = 16,
  parameter bit START_ON = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic tick
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= START_ON;
      cnt_q   <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (stop) begin
        running <= 1'b0;
        cnt_q   <= '0;
      end else if (start && !running) begin
        running <= 1'b1;
        cnt_q   <= '0;
      end else if (running) begin
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          tick  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rtcp_periodic_regfile.sv
module rtcp_periodic_regfile
  import rtcp_pkg::*;
#(
  parameter int PERIOD_CYCLES = 16,
  parameter int INIT_SEC      = 45,
  parameter int INIT_MIN      = 30,
  parameter int INIT_HOUR     = 13,
  parameter int INIT_WDAY     = 3,
  parameter int INIT_MDAY     = 21,
  parameter int INIT_MONTH    = 6,
  parameter int INIT_YEAR     = 107,
  parameter bit YEAR_BCD      = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic       req_port,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_rdata,
  output logic       err_pulse,
  output logic       tick_irq
);
  localparam bit TICK_AT_RESET = (B_RESET & B_TIE) != '0;

  logic              accept;
  logic [DATA_W-1:0] rd_value;
  logic              tmr_start, tmr_stop;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] stat_a;

  rtcp_host_port i_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rd_value(rd_value), .accept(accept)
  );

  rtcp_regfile #(
    .INIT_SEC(INIT_SEC), .INIT_MIN(INIT_MIN), .INIT_HOUR(INIT_HOUR),
    .INIT_WDAY(INIT_WDAY), .INIT_MDAY(INIT_MDAY), .INIT_MONTH(INIT_MONTH),
    .INIT_YEAR(INIT_YEAR), .YEAR_BCD(YEAR_BCD)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .wr(req_write), .port(req_port),
    .wdata(req_wdata), .rd_value(rd_value), .err_pulse(err_pulse),
    .tmr_start(tmr_start), .tmr_stop(tmr_stop), .idx_q(idx_q), .stat_a(stat_a)
  );

  rtcp_tick_timer #(.PERIOD(PERIOD_CYCLES), .START_ON(TICK_AT_RESET)) i_tick (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .stop(tmr_stop), .tick(tick_irq)
  );
endmodule

// File: rtl/rtcp_checker.sv
module rtcp_checker #(
  parameter int PERIOD = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic       req_port,
  input logic [7:0] req_wdata,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_rdata,
  input logic       err_pulse,
  input logic       tick_irq,
  input logic [3:0] idx_q,
  input logic [7:0] stat_a
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R1
  idx_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !req_port && (req_wdata > 8'h0D)) |=> (err_pulse && $stable(idx_q)));

  // R1
  idx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !req_port && (req_wdata <= 8'h0D)) |=> (idx_q == $past(req_wdata[3:0])));

  // R6
  uip_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_port && (idx_q == 4'hA)) |=>
      (rsp_valid && (rsp_rdata[7] != $past(stat_a[7])) && (stat_a[7] != $past(stat_a[7]))));

  // R9
  cd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_port && (idx_q >= 4'hC)) |=> (rsp_rdata == 8'h00));

  // R13
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  if (PERIOD > 1) begin : g_single
    // R10
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |=> !tick_irq);
  end
endmodule

bind rtcp_periodic_regfile rtcp_checker #(.PERIOD(PERIOD_CYCLES)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_port(req_port), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .err_pulse(err_pulse), .tick_irq(tick_irq), .idx_q(idx_q), .stat_a(stat_a)
);

// File: tb/test_rtcp_periodic_regfile.sv
module test_rtcp_periodic_regfile;
  localparam int P     = 8;
  localparam int SEC   = 45, MIN = 30, HOUR = 13, WDAY = 3, MDAY = 21, MON = 6, YEAR = 107;
  localparam bit YBCD  = 1'b1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_port = 0, rsp_ready = 1;
  logic [7:0] req_wdata = 0;
  logic req_ready, rsp_valid, err_pulse, tick_irq;
  logic [7:0] rsp_rdata;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  rtcp_periodic_regfile #(
    .PERIOD_CYCLES(P), .INIT_SEC(SEC), .INIT_MIN(MIN), .INIT_HOUR(HOUR),
    .INIT_WDAY(WDAY), .INIT_MDAY(MDAY), .INIT_MONTH(MON), .INIT_YEAR(YEAR), .YEAR_BCD(YBCD)
  ) i_rtcp_periodic_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_port(req_port), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .err_pulse(err_pulse), .tick_irq(tick_irq)
  );

  int irq_seen = 0;
  always @(negedge clk) if (rst_n && tick_irq) irq_seen++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit port, input logic [7:0] d, output bit e);
    req_valid = 1; req_write = 1; req_port = port; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    e = err_pulse;
  endtask

  task automatic rd(input bit port, output logic [7:0] d);
    req_valid = 1; req_write = 0; req_port = port;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
    check(rsp_valid == 1'b1, "R13 response valid", rsp_valid, 1);
  endtask

  function automatic logic [7:0] cal_exp(input int i);
    case (i)
      0: return 8'(SEC);
      2: return 8'(MIN);
      4: return 8'(HOUR);
      6: return 8'(WDAY + 1);
      7: return 8'(MDAY);
      8: return 8'(MON + 1);
      9: return YBCD ? 8'((((YEAR % 100) / 10) << 4) | (YEAR % 10)) : 8'(YEAR);
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    bit e;
    logic [7:0] d, a_model, b_model, idx_model;
    int base;

    repeat (3) @(negedge clk);
    rst_n = 1;
    check(err_pulse == 0 && rsp_valid == 0 && req_ready == 1, "R5 reset outputs", {err_pulse, rsp_valid}, 0);

    // R10: pulse after each group of P edges from reset, one cycle wide
    for (int per = 0; per < 3; per++) begin
      int early = 0;
      for (int k = 1; k <= P; k++) begin
        @(negedge clk);
        if (k < P && tick_irq) early++;
        if (k == P) check(tick_irq == 1, "R10 tick at terminal count", tick_irq, 1);
      end
      check(early == 0, "R10 no tick between terminals", early, 0);
    end

    // R3 R4: reset calendar
    for (int i = 0; i < 10; i++) begin
      wr(0, 8'(i), e);
      rd(1, d);
      check(d == cal_exp(i), (i == 9) ? "R4 year byte" : "R3 calendar reset", d, cal_exp(i));
    end

    // R5 R6: status A toggling, control B reset
    wr(0, 8'h0A, e);
    rd(1, d); check(d == 8'hA6, "R6 first A read", d, 8'hA6);
    rd(1, d); check(d == 8'h26, "R6 second A read", d, 8'h26);
    rd(1, d); check(d == 8'hA6, "R5 R6 third A read", d, 8'hA6);
    a_model = 8'hA6;
    wr(0, 8'h0B, e);
    rd(1, d); check(d == 8'h46, "R5 B reset", d, 8'h46);

    // R1: full index sweep
    idx_model = 8'h0B;
    for (int v = 0; v < 256; v++) begin
      wr(0, 8'(v), e);
      check(e == (v > 13), "R1 index error flag", e, (v > 13));
      if (v <= 13) idx_model = 8'(v);
      rd(0, d);
      check(d == idx_model, "R1 index readback", d, idx_model);
    end

    // R13: error pulse lasts one cycle
    wr(0, 8'hFF, e);
    @(negedge clk);
    check(err_pulse == 0, "R13 error one cycle", err_pulse, 0);

    // R2: calendar write/read, two patterns
    for (int pat = 0; pat < 2; pat++) begin
      for (int i = 0; i < 10; i++) begin
        wr(0, 8'(i), e);
        wr(1, 8'(i * 37 + 5) ^ (pat ? 8'hFF : 8'h00), e);
        check(e == 0, "R2 calendar write no error", e, 0);
      end
      for (int i = 0; i < 10; i++) begin
        logic [7:0] x;
        x = 8'(i * 37 + 5) ^ (pat ? 8'hFF : 8'h00);
        wr(0, 8'(i), e);
        rd(1, d);
        check(d == x, "R2 calendar readback", d, x);
      end
    end

    // R7: register A write sweep
    wr(0, 8'h0A, e);
    for (int v = 0; v < 256; v++) begin
      wr(1, 8'(v), e);
      check(e == (v != 8'h26), "R7 A write error", e, (v != 8'h26));
      if (v == 8'h26) a_model = 8'h26;
      rd(1, d);
      a_model = a_model ^ 8'h80;
      check(d == a_model, "R7 R6 A readback", d, a_model);
    end

    // R8: register B write sweep
    wr(0, 8'h0B, e);
    b_model = 8'h46;
    for (int v = 0; v < 256; v++) begin
      bit ok;
      ok = ((v & 8'hB7) == 8'h06);
      wr(1, 8'(v), e);
      check(e == !ok, "R8 B write error", e, !ok);
      if (ok) b_model = 8'(v);
      rd(1, d);
      check(d == b_model, "R8 B readback", d, b_model);
    end

    // R9: registers C and D
    for (int r = 12; r <= 13; r++) begin
      wr(0, 8'(r), e);
      rd(1, d); check(d == 0, "R9 C/D read zero", d, 0);
      wr(1, 8'h55, e); check(e == 1, "R9 C/D write error", e, 1);
      wr(1, 8'h00, e); check(e == 1, "R9 C/D write error zero", e, 1);
      rd(1, d); check(d == 0, "R9 C/D still zero", d, 0);
    end

    // R13: back-pressure on the response
    wr(0, 8'h02, e);
    wr(1, 8'h5A, e);
    rsp_ready = 0;
    rd(1, d);
    check(d == 8'h5A, "R13 stalled data", d, 8'h5A);
    check(req_ready == 0, "R13 ready low while stalled", req_ready, 0);
    req_valid = 1; req_write = 1; req_port = 0; req_wdata = 8'h05;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1 && rsp_rdata == 8'h5A, "R13 response held", rsp_rdata, 8'h5A);
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check(rsp_valid == 0, "R13 response drained", rsp_valid, 0);
    rd(0, d);
    check(d == 8'h05, "R13 stalled write taken once", d, 8'h05);

    // R11: stop, then restart
    wr(0, 8'h0B, e);
    wr(1, 8'h06, e);
    base = irq_seen;
    repeat (3 * P) @(negedge clk);
    check(irq_seen == base, "R11 no tick while stopped", irq_seen - base, 0);
    wr(1, 8'h4E, e);
    base = irq_seen;
    repeat (P - 1) @(negedge clk);
    check(irq_seen == base, "R10 no tick before first period", irq_seen - base, 0);
    @(negedge clk);
    check(tick_irq == 1, "R10 tick one period after start", tick_irq, 1);

    // R12: stop taken on the terminal-count edge
    repeat (P - 1) @(negedge clk);
    base = irq_seen;
    wr(1, 8'h06, e);
    check(tick_irq == 0, "R12 stop beats terminal count", tick_irq, 0);
    repeat (3 * P) @(negedge clk);
    check(irq_seen == base, "R12 R11 silent after stop", irq_seen - base, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule